// File: doc/BRIEF.md
# Combined Channel-Pair PWM Generator

This block builds one edge-aligned PWM waveform from a pair of timer channels. An up-counter runs from a programmable start count to a programmable modulus and then starts again, so the period is `modulus - init_cnt + 1` clock cycles. The even channel and the odd channel each hold a 16-bit compare value. The smaller of the two values marks the leading edge of the pulse and the larger one marks the trailing edge. The pulse width is therefore the absolute difference between the two values, whichever channel holds the larger one. The waveform leaves the block on the even channel's pin.

Each channel has its own sticky event flag and its own interrupt request. A flag is set when the counter equals that channel's compare value, and it stays set until it is cleared by a one-cycle clear pulse. Each interrupt request is the flag gated by that channel's enable.

The modulus and both compare values are sampled from the inputs only at the counter reload point, so a write in the middle of a period cannot distort the current pulse. The pairing takes effect only under one mode selection: quadrature decoding off, dual-edge capture off, pairing on and center-aligned counting off. Under any other selection the pin rests at its inactive level and neither flag can be set.

Top module: `pair_pwm_gen`

## Requirements
- R1: The paired mode is active only when `qdec_en`=0, `dcap_en`=0, `pair_en`=1 and `center_en`=0. Under any other combination, from the next cycle on, `pwm_out` rests at its inactive level and no flag is set.
- R2: The counter counts up by one per cycle. In the cycle after it equals the active modulus, it loads `init_cnt`. The period is modulus - init_cnt + 1 cycles, which shows as the spacing between successive even-flag set events.
- R3: With `pol_inv`=0, `pwm_out` goes to 1 in the cycle after the counter equals the lower compare value. It returns to 0 in the cycle after the counter equals the higher compare value or the modulus. The width is |cmp_odd - cmp_even| cycles per period for either ordering of the two values.
- R4: When the two active compare values are equal, `pwm_out` stays at its inactive level for the whole period.
- R5: With `pol_inv`=1, the output level is inverted: the inactive level is 1 and the pulse is driven low.
- R6: `flag_even` (or `flag_odd`) is set in the cycle after the counter equals the active even (or odd) compare value while the mode is active. It stays set until a cycle with `clr_even` (or `clr_odd`) high. A set event wins over a clear in the same cycle.
- R7: `irq_even` equals `flag_even` AND `irq_en_even`, and `irq_odd` equals `flag_odd` AND `irq_en_odd`.
- R8: The modulus and both compare values are taken from the inputs only in the cycle where the counter equals the active modulus. Changes at other times have no effect until the next reload.
- R9: While `rst_n` is low, the counter and the active modulus and compare values are 0, `pwm_out` is 0 (with `pol_inv`=0), and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_cnt | input | 16 | Count loaded at each reload |
| modulus | input | 16 | Terminal count (sampled at reload) |
| cmp_even | input | 16 | Even-channel compare value (sampled at reload) |
| cmp_odd | input | 16 | Odd-channel compare value (sampled at reload) |
| qdec_en | input | 1 | Quadrature decode selected (blocks pairing) |
| dcap_en | input | 1 | Dual-edge capture selected (blocks pairing) |
| pair_en | input | 1 | Pair the two channels into one PWM |
| center_en | input | 1 | Center-aligned counting selected (blocks pairing) |
| pol_inv | input | 1 | Invert output polarity |
| irq_en_even | input | 1 | Interrupt enable, even channel |
| irq_en_odd | input | 1 | Interrupt enable, odd channel |
| clr_even | input | 1 | Clear pulse for the even flag |
| clr_odd | input | 1 | Clear pulse for the odd flag |
| pwm_out | output | 1 | PWM waveform on the even channel pin |
| flag_even | output | 1 | Even-channel match flag |
| flag_odd | output | 1 | Odd-channel match flag |
| irq_even | output | 1 | Even-channel interrupt request |
| irq_odd | output | 1 | Odd-channel interrupt request |

## Verification
The PWM function is driven with a table of settings: compare pairs in ascending and descending order, a pair of equal values, a nonzero start count that coincides with the lower edge, a trailing edge equal to the modulus, a two-cycle period and inverted polarity. Counting active cycles over four periods separates a correct width from a signed or one-off difference. The spacing of the flag events separates a correct reload from an off-by-one period. A compare rewrite in the middle of a period tells a shadowed update from a live one. Each of the four mode bits is then toggled on its own, to show that every one of them blocks the output and the flags.

// File: rtl/pair_pwm_pkg.sv
package pair_pwm_pkg;

    // Number of channels joined into one pair, and their positions.
    localparam int NUM_CH  = 2;
    localparam int CH_EVEN = 0;
    localparam int CH_ODD  = 1;

    // The pair runs only under one exact combination of mode bits.
    function automatic logic pair_mode_on(input logic qdec,
                                          input logic dcap,
                                          input logic pair,
                                          input logic center);
        return !qdec && !dcap && pair && !center;
    endfunction

endpackage

// File: rtl/pair_pwm_counter.sv
module pair_pwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] init_val,
    input  logic [W-1:0] mod_act,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == mod_act);
        if (wrap) begin
            st_d.cnt = init_val;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/pair_pwm_shadow.sv
module pair_pwm_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] mod_in,
    input  logic [W-1:0] cmp_a_in,
    input  logic [W-1:0] cmp_b_in,
    output logic [W-1:0] mod_act,
    output logic [W-1:0] cmp_a_act,
    output logic [W-1:0] cmp_b_act
);

    typedef struct packed {
        logic [W-1:0] modv;
        logic [W-1:0] cmp_a;
        logic [W-1:0] cmp_b;
    } shadow_state_t;

    shadow_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.modv  = mod_in;
            st_d.cmp_a = cmp_a_in;
            st_d.cmp_b = cmp_b_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_act   = st_q.modv;
    assign cmp_a_act = st_q.cmp_a;
    assign cmp_b_act = st_q.cmp_b;

endmodule

// File: rtl/pair_pwm_edge.sv
module pair_pwm_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         wrap,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    output logic         on
);

    typedef struct packed {
        logic on;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [W-1:0] lo_edge;
    logic [W-1:0] hi_edge;

    always_comb begin
        st_d    = st_q;
        lo_edge = (cmp_a < cmp_b) ? cmp_a : cmp_b;
        hi_edge = (cmp_a < cmp_b) ? cmp_b : cmp_a;
        // The trailing edge is checked before the leading one, so equal
        // compare values never open a pulse.
        if (!enable || wrap) begin
            st_d.on = 1'b0;
        end else if (cnt == hi_edge) begin
            st_d.on = 1'b0;
        end else if (cnt == lo_edge) begin
            st_d.on = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign on = st_q.on;

endmodule

// File: rtl/pair_pwm_flag.sv
module pair_pwm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & irq_en;

endmodule

// File: rtl/pair_pwm_gen.sv
module pair_pwm_gen
    import pair_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] init_cnt,
    input  logic [CNT_W-1:0] modulus,
    input  logic [CNT_W-1:0] cmp_even,
    input  logic [CNT_W-1:0] cmp_odd,
    input  logic             qdec_en,
    input  logic             dcap_en,
    input  logic             pair_en,
    input  logic             center_en,
    input  logic             pol_inv,
    input  logic             irq_en_even,
    input  logic             irq_en_odd,
    input  logic             clr_even,
    input  logic             clr_odd,
    output logic             pwm_out,
    output logic             flag_even,
    output logic             flag_odd,
    output logic             irq_even,
    output logic             irq_odd
);

    logic             mode_ok;
    logic             wrap;
    logic             on_lvl;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mod_act;
    logic [CNT_W-1:0] c0_act;
    logic [CNT_W-1:0] c1_act;

    logic [CNT_W-1:0] cmp_act [NUM_CH];
    logic [NUM_CH-1:0] hit_v;
    logic [NUM_CH-1:0] clr_v;
    logic [NUM_CH-1:0] en_v;
    logic [NUM_CH-1:0] flag_v;
    logic [NUM_CH-1:0] irq_v;

    assign mode_ok = pair_mode_on(qdec_en, dcap_en, pair_en, center_en);

    pair_pwm_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_val (init_cnt),
        .mod_act  (mod_act),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    pair_pwm_shadow #(.W(CNT_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wrap),
        .mod_in    (modulus),
        .cmp_a_in  (cmp_even),
        .cmp_b_in  (cmp_odd),
        .mod_act   (mod_act),
        .cmp_a_act (c0_act),
        .cmp_b_act (c1_act)
    );

    pair_pwm_edge #(.W(CNT_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mode_ok),
        .wrap   (wrap),
        .cnt    (cnt),
        .cmp_a  (c0_act),
        .cmp_b  (c1_act),
        .on     (on_lvl)
    );

    assign cmp_act[CH_EVEN] = c0_act;
    assign cmp_act[CH_ODD]  = c1_act;
    assign clr_v  = {clr_odd, clr_even};
    assign en_v   = {irq_en_odd, irq_en_even};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        assign hit_v[i] = mode_ok && (cnt == cmp_act[i]);

        pair_pwm_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit_v[i]),
            .clr    (clr_v[i]),
            .irq_en (en_v[i]),
            .flag   (flag_v[i]),
            .irq    (irq_v[i])
        );
    end

    assign pwm_out   = on_lvl ^ pol_inv;
    assign flag_even = flag_v[CH_EVEN];
    assign flag_odd  = flag_v[CH_ODD];
    assign irq_even  = irq_v[CH_EVEN];
    assign irq_odd   = irq_v[CH_ODD];

endmodule

// File: rtl/pair_pwm_chk.sv
module pair_pwm_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_ok,
    input logic         wrap,
    input logic [W-1:0] cnt,
    input logic [W-1:0] init_cnt,
    input logic [W-1:0] mod_act,
    input logic [W-1:0] c0_act,
    input logic [W-1:0] c1_act,
    input logic         pol_inv,
    input logic         pwm_out,
    input logic         flag_even,
    input logic         flag_odd,
    input logic         clr_even,
    input logic         clr_odd,
    input logic         irq_en_even,
    input logic         irq_en_odd,
    input logic         irq_even,
    input logic         irq_odd
);

    logic [W-1:0] hi_act;
    assign hi_act = (c0_act < c1_act) ? c1_act : c0_act;

    assert_idle_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> (pwm_out == pol_inv));

    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == $past(init_cnt)));

    assert_trail_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && cnt == hi_act) |=> (pwm_out == pol_inv));

    assert_equal_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_act == c1_act) |-> (pwm_out == pol_inv));

    assert_even_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && cnt == c0_act) |=> flag_even);

    assert_odd_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ok && cnt == c1_act) |=> flag_odd);

    assert_even_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_even && !clr_even) |=> flag_even);

    assert_odd_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_odd && !clr_odd) |=> flag_odd);

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_even |-> !irq_even) and (!irq_en_odd |-> !irq_odd)
        and (irq_even |-> flag_even) and (irq_odd |-> flag_odd));

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(mod_act) && $stable(c0_act) && $stable(c1_act)));

endmodule

bind pair_pwm_gen pair_pwm_chk #(.W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_ok     (mode_ok),
    .wrap        (wrap),
    .cnt         (cnt),
    .init_cnt    (init_cnt),
    .mod_act     (mod_act),
    .c0_act      (c0_act),
    .c1_act      (c1_act),
    .pol_inv     (pol_inv),
    .pwm_out     (pwm_out),
    .flag_even   (flag_even),
    .flag_odd    (flag_odd),
    .clr_even    (clr_even),
    .clr_odd     (clr_odd),
    .irq_en_even (irq_en_even),
    .irq_en_odd  (irq_en_odd),
    .irq_even    (irq_even),
    .irq_odd     (irq_odd)
);

// File: tb/pair_pwm_gen_tb.sv
module pair_pwm_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] init_cnt, modulus, cmp_even, cmp_odd;
    logic        qdec_en, dcap_en, pair_en, center_en, pol_inv;
    logic        irq_en_even, irq_en_odd, clr_even, clr_odd;
    logic        pwm_out, flag_even, flag_odd, irq_even, irq_odd;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pair_pwm_gen u_dut (
        .clk(clk), .rst_n(rst_n), .init_cnt(init_cnt), .modulus(modulus),
        .cmp_even(cmp_even), .cmp_odd(cmp_odd), .qdec_en(qdec_en),
        .dcap_en(dcap_en), .pair_en(pair_en), .center_en(center_en),
        .pol_inv(pol_inv), .irq_en_even(irq_en_even), .irq_en_odd(irq_en_odd),
        .clr_even(clr_even), .clr_odd(clr_odd), .pwm_out(pwm_out),
        .flag_even(flag_even), .flag_odd(flag_odd), .irq_even(irq_even),
        .irq_odd(irq_odd)
    );

    typedef struct packed {
        logic [15:0] ini;
        logic [15:0] modv;
        logic [15:0] ce;
        logic [15:0] co;
        logic        pol;
        int          width;
        int          period;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{16'd0,   16'd9,   16'd2,   16'd6,   1'b0, 4,  10},
        '{16'd0,   16'd9,   16'd6,   16'd2,   1'b0, 4,  10},
        '{16'd3,   16'd12,  16'd3,   16'd12,  1'b0, 9,  10},
        '{16'd0,   16'd7,   16'd4,   16'd4,   1'b0, 0,  8},
        '{16'd5,   16'd20,  16'd8,   16'd15,  1'b1, 7,  16},
        '{16'd0,   16'd1,   16'd0,   16'd1,   1'b0, 1,  2},
        '{16'd100, 16'd199, 16'd150, 16'd100, 1'b1, 50, 100}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Returns at a negedge just after a genuine even-flag set event.
    task automatic sync_even();
        int hits = 0;
        while (hits < 2) begin
            @(negedge clk);
            clr_even = 1'b0;
            if (flag_even) begin
                hits++;
                if (hits < 2) clr_even = 1'b1;
            end
        end
    endtask

    task automatic measure_period(output int n);
        sync_even();
        clr_even = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            clr_even = 1'b0;
            n++;
        end while (!flag_even);
    endtask

    task automatic count_active(input int cycles, input logic pol, output int on);
        on = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pwm_out ^ pol) on++;
        end
    endtask

    task automatic apply(input vec_t v);
        init_cnt = v.ini; modulus = v.modv;
        cmp_even = v.ce;  cmp_odd = v.co;
        pol_inv  = v.pol;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int on;
        int per;
        rst_n = 1'b0;
        apply(VECS[0]);
        qdec_en = 0; dcap_en = 0; pair_en = 1; center_en = 0;
        irq_en_even = 0; irq_en_odd = 0; clr_even = 0; clr_odd = 0;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R9 pwm_out in reset", pwm_out, 0);
        check(flag_even == 1'b0 && flag_odd == 1'b0, "R9 flags in reset",
              {flag_odd, flag_even}, 0);
        rst_n = 1'b1;

        // Table walk: R3 width (R4 equal, R5 inverted), R2 period
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            repeat (220) @(negedge clk);
            count_active(4 * VECS[i].period, VECS[i].pol, on);
            if (VECS[i].width == 0)
                check(on == 0, "R4 equal compares idle", on, 0);
            else if (VECS[i].pol)
                check(on == 4 * VECS[i].width, "R5 inverted width", on, 4 * VECS[i].width);
            else
                check(on == 4 * VECS[i].width, "R3 pulse width", on, 4 * VECS[i].width);
            measure_period(per);
            check(per == VECS[i].period, "R2 period", per, VECS[i].period);
        end

        // R8: mid-period rewrite must not alter the current pulse
        apply(VECS[0]);
        repeat (220) @(negedge clk);
        sync_even();
        check(pwm_out == 1'b1, "R3 pulse open after lower match", pwm_out, 1);
        modulus = 16'd5; cmp_even = 16'd1; cmp_odd = 16'd3;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check(pwm_out == 1'b1, "R8 old trailing edge kept", pwm_out, 1);
        end
        @(negedge clk);
        check(pwm_out == 1'b0, "R8 pulse ends at old edge", pwm_out, 0);
        measure_period(per);
        check(per == 6, "R8 new modulus after reload", per, 6);
        count_active(24, 1'b0, on);
        check(on == 8, "R8 new compares after reload", on, 8);

        // R6 and R7: odd flag timing, stickiness, clear, interrupt gating
        apply(VECS[0]);
        repeat (40) @(negedge clk);
        sync_even();
        clr_odd = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            clr_odd = 1'b0;
            check(flag_odd == 1'b0, "R6 odd flag before match", flag_odd, 0);
        end
        @(negedge clk);
        check(flag_odd == 1'b1, "R6 odd flag on match", flag_odd, 1);
        @(negedge clk);
        check(flag_even == 1'b1, "R6 even flag sticky", flag_even, 1);
        check(irq_even == 1'b0, "R7 even irq masked", irq_even, 0);
        check(irq_odd == 1'b0, "R7 odd irq masked", irq_odd, 0);
        irq_en_even = 1'b1; irq_en_odd = 1'b1;
        #1;
        check(irq_even == 1'b1, "R7 even irq enabled", irq_even, 1);
        check(irq_odd == 1'b1, "R7 odd irq enabled", irq_odd, 1);
        irq_en_even = 1'b0; irq_en_odd = 1'b0;
        repeat (3) @(negedge clk);
        check(flag_odd == 1'b1, "R6 odd flag sticky", flag_odd, 1);
        clr_odd = 1'b1;
        @(negedge clk);
        clr_odd = 1'b0;
        check(flag_odd == 1'b0, "R6 odd flag cleared", flag_odd, 0);

        // R1: each blocking mode bit on its own
        for (int m = 0; m < 4; m++) begin
            int bad = 0;
            qdec_en = (m == 0); dcap_en = (m == 1);
            pair_en = (m != 2); center_en = (m == 3);
            pol_inv = (m == 1);
            @(negedge clk);
            clr_even = 1'b1; clr_odd = 1'b1;
            @(negedge clk);
            clr_even = 1'b0; clr_odd = 1'b0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (pwm_out != pol_inv || flag_even || flag_odd) bad++;
            end
            check(bad == 0, "R1 mode blocked output and flags", bad, 0);
        end
        qdec_en = 0; dcap_en = 0; pair_en = 1; center_en = 0; pol_inv = 0;
        measure_period(per);
        check(per == 10, "R1 mode restored", per, 10);

        summary();
        $finish;
    end

endmodule